// File: doc/BRIEF.md
# Bus-Attached Successive-Approximation Converter Controller

This block is the digital half of an 8-bit successive-approximation converter that hangs on a processor bus. A host selects the block with an active-low chip select. It writes a 5-bit channel/mode address on the low data lines with an active-low write strobe. That write also starts a conversion. The host fetches the result with an active-low read strobe. An active-low interrupt output reports that a fresh result is waiting. The analog multiplexer, the reference ladder and the comparator are outside the block. The block drives them through a one-hot positive select, a one-hot negative select (whose top bit means analog ground) and a trial code. It receives one comparator bit back, which is 1 when the selected positive-minus-negative voltage is at or above the trial level.

All three bus strobes are asynchronous. Each one is brought into the system clock through two flops and then edge-detected. The approximation tests one bit per step, starting from the MSB. Each step lasts a configurable number of settle cycles. A read also restarts a conversion on the configuration already in place. A write may follow a read at once, without waiting for that conversion. The data bus is modelled as a read-data output with an output enable. A low enable stands for high impedance.

Top module: `sar_bus_ctrl`

## Requirements
- R1: After reset, intr_n is 1, db_oe is 0, trial_code is 0, pos_sel selects channel 0 (value 1) and neg_sel selects ground (only bit NCH set).
- R2: A write with cs_n low and rd_n high loads addr_in on the rising edge of wr_n. If the address is valid, the selects take the decoded configuration. The addr_in bits [LOG+1:LOG] (LOG = log2 NCH) give the mode: 00 differential, 01 single-ended, 11 pseudo-differential, 10 reserved. The channel index is addr_in[LOG-1:0].
- R3: In differential mode the positive select is the channel index and the negative select is that index with bit 0 inverted. With NCH=8, address 03h gives positive channel 3 and negative channel 2.
- R4: In single-ended mode the negative select is ground (neg_sel bit NCH). In pseudo-differential mode the negative select is channel NCH-1. With NCH=8, 0Ah selects channel 2 against ground and 19h selects channel 1 against channel 7.
- R5: A reserved mode, a pseudo-differential index of NCH-1, or a nonzero address bit above LOG+1 leaves both selects unchanged.
- R6: If rd_n stays low for the whole low period of wr_n, both selects stay unchanged and the previously latched result is driven with db_oe high.
- R7: A falling edge of wr_n while cs_n is low drives intr_n high before wr_n rises again.
- R8: A conversion tests RES bits, MSB first, with SETTLE_CYC cycles per bit. The result is the largest code whose every kept bit saw the comparator at 1. The result is latched, and intr_n goes low within RES*SETTLE_CYC+10 cycles of the strobe that started it.
- R9: When the negative input is above the positive input, the result is 0.
- R10: With cs_n and rd_n both low, intr_n goes high, db_oe goes high and db_out carries the latched result. The read also starts a new conversion on the unchanged configuration.
- R11: db_oe is 0 whenever no read (cs_n and rd_n both low) is in progress.
- R12: Strobes given while cs_n is high change neither the selects, intr_n nor db_oe.
- R13: A write issued right after a read, with no wait for the read-started conversion, produces a result for the newly written configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| wr_n | input | 1 | Write strobe, active low, asynchronous |
| rd_n | input | 1 | Read strobe, active low, asynchronous |
| addr_in | input | 5 | Low data lines carrying the channel/mode address |
| db_out | output | RES | Read data, valid while db_oe is high |
| db_oe | output | 1 | Data bus drive enable; low means high impedance |
| intr_n | output | 1 | End-of-conversion interrupt, active low |
| pos_sel | output | NCH | One-hot positive input select |
| neg_sel | output | NCH+1 | One-hot negative input select, bit NCH is analog ground |
| trial_code | output | RES | Code under test presented to the reference ladder |
| cmp_in | input | 1 | Comparator result, 1 when input difference is at or above trial level |

## Verification
A strobe edge reaches the logic after two synchronizer flops and an edge-detect flop, and the state it changes is registered once more. So the selects, db_oe, db_out and the interrupt clear are due about four cycles after the edge. The bench drives on the falling clock edge and waits five cycles before it samples. A conversion needs RES*SETTLE_CYC cycles after its start pulse, plus one for the interrupt. The bench polls intr_n once per cycle and counts a failure if it has not fallen within RES*SETTLE_CYC+10 cycles of the starting strobe. The comparator is modelled from per-channel values, so each expected result is the clamped channel difference worked out in the bench.

// File: rtl/sar_bus_pkg.sv
package sar_bus_pkg;

    localparam int ADDR_W = 5;

    typedef enum logic [1:0] {
        MODE_DIFF   = 2'b00,
        MODE_SINGLE = 2'b01,
        MODE_RSVD   = 2'b10,
        MODE_PSEUDO = 2'b11
    } in_mode_e;

    typedef enum logic {
        ENG_IDLE = 1'b0,
        ENG_RUN  = 1'b1
    } eng_state_e;

    typedef struct packed {
        logic cs_lo;
        logic wr_lo;
        logic rd_lo;
        logic wr_asrt;
        logic wr_rel;
    } bus_view_t;

endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] async_n,
    output logic [N-1:0] lvl_lo,
    output logic [N-1:0] asrt_p,
    output logic [N-1:0] rel_p
);
    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_strobe
            logic s1, s2, s3;
            always_ff @(posedge clk) begin
                if (rst) begin
                    s1 <= 1'b1;
                    s2 <= 1'b1;
                    s3 <= 1'b1;
                end else begin
                    s1 <= async_n[g];
                    s2 <= s1;
                    s3 <= s2;
                end
            end
            assign lvl_lo[g] = ~s2;
            assign asrt_p[g] = s3 & ~s2;
            assign rel_p[g]  = ~s3 & s2;
        end
    endgenerate
endmodule

// File: rtl/sar_mux_decode.sv
module sar_mux_decode
    import sar_bus_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              valid,
    output logic [$clog2(NCH)-1:0] pos_idx,
    output logic [$clog2(NCH):0]   neg_idx
);
    localparam int LOG = $clog2(NCH);
    localparam logic [LOG:0]   GND_IDX = (LOG+1)'(NCH);
    localparam logic [LOG-1:0] LAST_CH = LOG'(NCH - 1);

    in_mode_e       mode;
    logic [LOG-1:0] ch;
    logic           upper_ok;

    assign mode = in_mode_e'(addr[LOG+1:LOG]);
    assign ch   = addr[LOG-1:0];

    generate
        if (LOG + 2 < ADDR_W) begin : g_upper
            assign upper_ok = (addr[ADDR_W-1:LOG+2] == '0);
        end else begin : g_noupper
            assign upper_ok = 1'b1;
        end
    endgenerate

    always_comb begin
        pos_idx = ch;
        neg_idx = GND_IDX;
        valid   = upper_ok;
        unique case (mode)
            MODE_DIFF:   neg_idx = {1'b0, ch[LOG-1:1], ~ch[0]};
            MODE_SINGLE: neg_idx = GND_IDX;
            MODE_PSEUDO: begin
                neg_idx = {1'b0, LAST_CH};
                if (ch == LAST_CH) valid = 1'b0;
            end
            MODE_RSVD:   valid = 1'b0;
        endcase
    end
endmodule

// File: rtl/sar_engine.sv
module sar_engine
    import sar_bus_pkg::*;
#(
    parameter int RES        = 8,
    parameter int SETTLE_CYC = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic           cmp_in,
    output logic [RES-1:0] trial_code,
    output logic [RES-1:0] result,
    output logic           done,
    output logic           busy
);
    localparam int CW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
    localparam logic [RES-1:0] MSB_ONE = {1'b1, {(RES-1){1'b0}}};
    localparam logic [CW-1:0]  CNT_END = CW'(SETTLE_CYC - 1);

    eng_state_e     state;
    logic [RES-1:0] probe;
    logic [RES-1:0] code;
    logic [CW-1:0]  cnt;
    logic [RES-1:0] kept;

    assign kept       = cmp_in ? code : (code & ~probe);
    assign trial_code = code;
    assign busy       = (state == ENG_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ENG_IDLE;
            probe  <= '0;
            code   <= '0;
            cnt    <= '0;
            result <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                state <= ENG_RUN;
                probe <= MSB_ONE;
                code  <= MSB_ONE;
                cnt   <= '0;
            end else if (state == ENG_RUN) begin
                if (cnt == CNT_END) begin
                    cnt <= '0;
                    if (probe[0]) begin
                        result <= kept;
                        done   <= 1'b1;
                        code   <= '0;
                        probe  <= '0;
                        state  <= ENG_IDLE;
                    end else begin
                        code  <= kept | (probe >> 1);
                        probe <= probe >> 1;
                    end
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // R8: a start pulse always opens with only the MSB under test
    p_start_msb_r8: assert property (@(posedge clk) disable iff (rst)
        start |=> (trial_code == MSB_ONE));
    // R8: no trial level is presented while idle
    p_idle_zero_r8: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (trial_code == '0));
    // R8: completion leaves the engine idle
    p_done_idle_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
endmodule

// File: rtl/sar_bus_ctrl.sv
module sar_bus_ctrl
    import sar_bus_pkg::*;
#(
    parameter int NCH        = 8,
    parameter int RES        = 8,
    parameter int SETTLE_CYC = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic              rd_n,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [RES-1:0]    db_out,
    output logic              db_oe,
    output logic              intr_n,
    output logic [NCH-1:0]    pos_sel,
    output logic [NCH:0]      neg_sel,
    output logic [RES-1:0]    trial_code,
    input  logic              cmp_in
);
    localparam int LOG = $clog2(NCH);
    localparam logic [NCH:0] GND_SEL = {1'b1, {NCH{1'b0}}};

    logic [2:0] lo, asrt, rel;
    bus_view_t  bv;

    strobe_sync #(.N(3)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_n ({cs_n, wr_n, rd_n}),
        .lvl_lo  (lo),
        .asrt_p  (asrt),
        .rel_p   (rel)
    );

    assign bv.cs_lo   = lo[2];
    assign bv.wr_lo   = lo[1];
    assign bv.rd_lo   = lo[0];
    assign bv.wr_asrt = asrt[1] & lo[2];
    assign bv.wr_rel  = rel[1] & lo[2];

    logic           dec_valid;
    logic [LOG-1:0] dec_pos;
    logic [LOG:0]   dec_neg;

    sar_mux_decode #(.NCH(NCH)) u_dec (
        .addr    (addr_in),
        .valid   (dec_valid),
        .pos_idx (dec_pos),
        .neg_idx (dec_neg)
    );

    logic           rd_act, rd_act_q, rd_start;
    logic           keep_q, cfg_load, conv_start;
    logic           eng_done, eng_busy;
    logic [RES-1:0] eng_result, res_q;

    assign rd_act     = bv.cs_lo & bv.rd_lo;
    assign rd_start   = rd_act & ~rd_act_q;
    assign cfg_load   = bv.wr_rel & ~keep_q & ~bv.rd_lo & dec_valid;
    assign conv_start = bv.wr_rel | rd_start;

    sar_engine #(.RES(RES), .SETTLE_CYC(SETTLE_CYC)) u_eng (
        .clk        (clk),
        .rst        (rst),
        .start      (conv_start),
        .cmp_in     (cmp_in),
        .trial_code (trial_code),
        .result     (eng_result),
        .done       (eng_done),
        .busy       (eng_busy)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_act_q <= 1'b0;
            keep_q   <= 1'b0;
            pos_sel  <= NCH'(1);
            neg_sel  <= GND_SEL;
            res_q    <= '0;
            intr_n   <= 1'b1;
            db_oe    <= 1'b0;
            db_out   <= '0;
        end else begin
            rd_act_q <= rd_act;
            if (bv.wr_asrt)
                keep_q <= bv.rd_lo;
            else if (bv.wr_lo && !bv.rd_lo)
                keep_q <= 1'b0;
            if (cfg_load) begin
                pos_sel <= NCH'(1) << dec_pos;
                neg_sel <= (NCH+1)'(1) << dec_neg;
            end
            if (eng_done)
                res_q <= eng_result;
            if (bv.wr_asrt || rd_act)
                intr_n <= 1'b1;
            else if (eng_done)
                intr_n <= 1'b0;
            db_oe  <= rd_act;
            db_out <= rd_act ? res_q : '0;
        end
    end

    // R10: an active read leaves the interrupt inactive
    p_rd_clears_intr_r10: assert property (@(posedge clk) disable iff (rst)
        rd_act |=> intr_n);
    // R11: no drive without a read in progress
    p_oe_needs_read_r11: assert property (@(posedge clk) disable iff (rst)
        !rd_act |=> !db_oe);
    // R5 (also R6, R12): selects move only on an accepted load
    p_cfg_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !cfg_load |=> ($stable(pos_sel) && $stable(neg_sel)));
    // R3: one positive, one negative, never the same channel
    p_sel_legal_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot(pos_sel) && $onehot(neg_sel) && ((pos_sel & neg_sel[NCH-1:0]) == '0));
    // R8: an unread completion raises the interrupt
    p_done_intr_r8: assert property (@(posedge clk) disable iff (rst)
        (eng_done && !bv.wr_asrt && !rd_act) |=> !intr_n);
    // R4: a ground reference only ever appears on the negative side
    p_gnd_alone_r4: assert property (@(posedge clk) disable iff (rst)
        neg_sel[NCH] |-> (neg_sel[NCH-1:0] == '0));
endmodule

// File: tb/sim_sar_bus_ctrl.sv
module sim_sar_bus_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 8;
    localparam int RES        = 8;
    localparam int SETTLE_CYC = 4;
    localparam int CONV_MAX   = RES * SETTLE_CYC + 10;
    localparam int GND        = 1 << NCH;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1;
    logic [4:0]     addr_in = '0;
    logic [RES-1:0] db_out;
    logic           db_oe, intr_n;
    logic [NCH-1:0] pos_sel;
    logic [NCH:0]   neg_sel;
    logic [RES-1:0] trial_code;
    logic           cmp_in;

    int ana [0:NCH];
    int n_chk = 0, n_bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sar_bus_ctrl #(.NCH(NCH), .RES(RES), .SETTLE_CYC(SETTLE_CYC)) u0 (
        .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
        .addr_in(addr_in), .db_out(db_out), .db_oe(db_oe), .intr_n(intr_n),
        .pos_sel(pos_sel), .neg_sel(neg_sel), .trial_code(trial_code),
        .cmp_in(cmp_in)
    );

    // analog environment: difference of selected channel values against trial level
    always_comb begin
        int p, n;
        p = 0;
        n = 0;
        for (int i = 0; i < NCH; i++) if (pos_sel[i]) p = i;
        for (int i = 0; i <= NCH; i++) if (neg_sel[i]) n = i;
        cmp_in = ((ana[p] - ana[n]) >= int'(trial_code));
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int clampd(input int v);
        if (v < 0) return 0;
        if (v > 255) return 255;
        return v;
    endfunction

    task automatic bus_write(input logic [4:0] a);
        cs_n = 1'b0; tick(1);
        wr_n = 1'b0; tick(5);
        addr_in = a; tick(1);
        wr_n = 1'b1; tick(5);
        cs_n = 1'b1; tick(1);
    endtask

    task automatic wait_intr(input string req);
        int n;
        n = 0;
        while (intr_n && n < CONV_MAX) begin tick(1); n++; end
        check(!intr_n, req, n, CONV_MAX);
    endtask

    task automatic bus_read(input string req, input int exp);
        cs_n = 1'b0; rd_n = 1'b0; tick(5);
        check(db_oe === 1'b1, req, int'(db_oe), 1);
        check(db_out == RES'(exp), req, int'(db_out), exp);
        check(intr_n === 1'b1, req, int'(intr_n), 1);
        rd_n = 1'b1; cs_n = 1'b1; tick(5);
        check(db_oe === 1'b0, "R11", int'(db_oe), 0);
    endtask

    task automatic check_sel(input string req, input int p, input int n);
        check(pos_sel == NCH'(p), req, int'(pos_sel), p);
        check(neg_sel == (NCH+1)'(n), req, int'(neg_sel), n);
    endtask

    task automatic t_reset;
        check(intr_n === 1'b1, "R1", int'(intr_n), 1);
        check(db_oe === 1'b0, "R1", int'(db_oe), 0);
        check(trial_code == '0, "R1", int'(trial_code), 0);
        check_sel("R1", 1, GND);
    endtask

    task automatic t_single;
        bus_write(5'h0A);
        check_sel("R2 R4", 1 << 2, GND);
        wait_intr("R8");
        bus_read("R8 R10", ana[2]);
    endtask

    task automatic t_diff;
        bus_write(5'h03);
        check_sel("R3", 1 << 3, 1 << 2);
        wait_intr("R8");
        bus_read("R3 R8", clampd(ana[3] - ana[2]));
    endtask

    task automatic t_negative;
        bus_write(5'h02);
        check_sel("R3", 1 << 2, 1 << 3);
        wait_intr("R9");
        bus_read("R9", 0);
    endtask

    task automatic t_pseudo;
        bus_write(5'h19);
        check_sel("R4", 1 << 1, 1 << 7);
        wait_intr("R8");
        bus_read("R4", clampd(ana[1] - ana[7]));
    endtask

    task automatic t_full_scale;
        bus_write(5'h08);
        check_sel("R4", 1, GND);
        wait_intr("R8");
        bus_read("R8", 255);
    endtask

    task automatic t_reserved;
        bus_write(5'h10);
        check_sel("R5", 1, GND);
        bus_write(5'h1F);
        check_sel("R5", 1, GND);
        wait_intr("R8");
        bus_read("R5", 255);
    endtask

    task automatic t_wr_fall;
        bus_write(5'h0C);
        wait_intr("R8");
        cs_n = 1'b0; tick(1);
        wr_n = 1'b0; tick(5);
        check(intr_n === 1'b1, "R7", int'(intr_n), 1);
        addr_in = 5'h0C; tick(1);
        wr_n = 1'b1; tick(5);
        cs_n = 1'b1; tick(1);
        wait_intr("R8");
        bus_read("R7", ana[4]);
    endtask

    task automatic t_keep;
        bus_write(5'h0E);
        wait_intr("R8");
        cs_n = 1'b0; rd_n = 1'b0; tick(5);
        wr_n = 1'b0; tick(5);
        addr_in = 5'h0B; tick(1);
        wr_n = 1'b1; tick(5);
        check(db_oe === 1'b1, "R6", int'(db_oe), 1);
        check(db_out == RES'(ana[6]), "R6", int'(db_out), ana[6]);
        rd_n = 1'b1; tick(1);
        cs_n = 1'b1; tick(5);
        check_sel("R6", 1 << 6, GND);
    endtask

    task automatic t_cs_high;
        wait_intr("R8");
        wr_n = 1'b0; tick(5);
        addr_in = 5'h09; tick(1);
        wr_n = 1'b1; tick(5);
        rd_n = 1'b0; tick(5);
        check(db_oe === 1'b0, "R12", int'(db_oe), 0);
        check(intr_n === 1'b0, "R12", int'(intr_n), 0);
        rd_n = 1'b1; tick(5);
        check_sel("R12", 1 << 6, GND);
    endtask

    task automatic t_read_restart;
        bus_read("R10", ana[6]);
        wait_intr("R10");
        ana[6] = 99;
        bus_read("R10", 128);
        wait_intr("R10");
        bus_read("R10", 99);
    endtask

    task automatic t_read_then_write;
        cs_n = 1'b0; rd_n = 1'b0; tick(5);
        rd_n = 1'b1; tick(1);
        wr_n = 1'b0; tick(3);
        addr_in = 5'h0B; tick(1);
        wr_n = 1'b1; tick(5);
        cs_n = 1'b1; tick(1);
        check_sel("R13", 1 << 3, GND);
        wait_intr("R13");
        bus_read("R13", ana[3]);
    endtask

    initial begin
        ana[0] = 255; ana[1] = 200; ana[2] = 77; ana[3] = 150; ana[4] = 10;
        ana[5] = 33;  ana[6] = 128; ana[7] = 60; ana[8] = 0;
        tick(4);
        rst = 1'b0;
        tick(2);
        t_reset();
        t_single();
        t_diff();
        t_negative();
        t_pseudo();
        t_full_scale();
        t_reserved();
        t_wr_fall();
        t_keep();
        t_cs_high();
        t_read_restart();
        t_read_then_write();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule